// File: doc/BRIEF.md
# Clock-Synchronous Full-Duplex Serial Master

This block is a serial master that drives its own serial clock and moves one frame out on `mosi` while it takes one frame in from `miso`. Frames are 8 to 16 bits long, sent most-significant bit first. The serial clock idles high. Output data changes on the falling edge and input data is sampled on the rising edge. Each half period of the serial clock lasts a programmable number of system clocks.

The host side has a transmit holding register and a receive holding register. It also has four status flags: transmit-empty, transmit-end, receive-full and overrun. Separate transmit-enable and receive-enable levels select one of three modes: full duplex, transmit only or receive only. Clocking goes on only while there is work. In the transmit modes, a new frame follows only when fresh data was written before the last rising edge of the current frame. In receive-only mode, frames follow one another until an overrun occurs. Because of this rule, the order in which the two enables are dropped decides whether any further clock pulses appear.

A soft-reset level, raised and then lowered, returns the transfer control to idle. Configuration inputs and the receive holding register are not affected.

Top module: `csu_duplex`

## Requirements
- R1: After reset, `sck` = 1, `tx_empty` = 1, `tx_end` = 1, `rx_full` = 0, `overrun` = 0 and `rx_rdata` = 0.
- R2: In the idle state, with `tx_en` = 1 and no overrun, a `tx_wr` pulse clears `tx_empty` on the next edge. On the edge after that, the data is copied into the shifter, `tx_empty` returns to 1 and the first falling `sck` edge occurs.
- R3: `frame_len` selects the frame length, clamped to the range 8 to 16. Each frame produces exactly that many rising `sck` edges.
- R4: Each `sck` half period lasts `div_half` system clocks, with 0 treated as 1. Bit `len-1` of the frame word goes out first. `mosi` changes only at falling edges, so it is stable at every rising edge.
- R5: If new data was written before the last rising edge of a frame, the next frame begins at the following falling edge with no idle gap. Otherwise clocking stops with `sck` high.
- R6: `tx_end` is set when a frame ends in a transmit mode with no data pending. Any `tx_wr` clears it.
- R7: At the last rising edge of a frame with `rx_en` = 1 and `rx_full` = 0, the received bits go into `rx_rdata`, right-aligned, with the bits above the frame length at zero. `rx_full` is then set. An `rx_rd` pulse clears `rx_full`.
- R8: A frame that ends with `rx_en` = 1 while `rx_full` is still 1 sets `overrun`, leaves `rx_rdata` unchanged and stops all clocking. Pending transmit data stays pending. Pulsing `ovr_clr` clears `overrun`, and the pending frame then starts.
- R9: With `rx_en` = 0, frames go out but neither `rx_full` nor `rx_rdata` changes.
- R10: With `rx_en` = 1 and `tx_en` = 0, frames run one after another with no write. They stop only on overrun, or at a frame end after `rx_en` is cleared.
- R11: When transfers are finished, clearing `rx_en` before or together with `tx_en` produces no further `sck` pulse. Clearing only `tx_en` starts receive-only clocking.
- R12: While `soft_rst` = 1, the block is idle with `sck` = 1, `tx_empty` = 1, `tx_end` = 1, `rx_full` = 0, `overrun` = 0 and both shifters cleared. `rx_rdata` is kept. After `soft_rst` returns to 0, no frame starts until data is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset of the transfer control (level) |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| frame_len | input | LEN_W (5) | Frame length in bits, clamped to 8..16 |
| div_half | input | DIV_W (8) | System clocks per `sck` half period (0 acts as 1) |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | MAX_LEN (16) | Transmit data, right-aligned |
| rx_rd | input | 1 | Read strobe; clears `rx_full` |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_rdata | output | MAX_LEN (16) | Receive holding register |
| tx_empty | output | 1 | Transmit holding register is free |
| tx_end | output | 1 | Transmission finished with nothing pending |
| rx_full | output | 1 | Unread received frame present |
| overrun | output | 1 | A frame ended while `rx_full` was set |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs a behavioural reference model next to the design and compares every output on every cycle. Directed sequences go after the corner cases: a write that arrives just before a frame's last rising edge, and a write that lands on the same edge as the reload. A design that decides at the wrong edge would leave an idle gap or send a frame twice. A second frame with unread receive data must stop the clock and keep the first word; a wrong design would keep clocking or overwrite `rx_rdata`. All three orders of dropping the enables are exercised, and only the transmit-enable-only order may produce pulses. A wrong start condition either hides that behaviour or emits pulses in the safe orders. Clamped frame lengths, a zero divider and a mid-frame soft reset complete the set.

// File: rtl/csu_pkg.sv
package csu_pkg;
   typedef enum logic {
      CSU_IDLE = 1'b0,
      CSU_RUN  = 1'b1
   } csu_state_e;
endpackage

// File: rtl/csu_sckgen.sv
module csu_sckgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/csu_shift.sv
module csu_shift #(
   parameter int MAX_LEN = 16,
   parameter int LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               load,
   input  logic [MAX_LEN-1:0] load_val,
   input  logic               shift,
   input  logic               sample,
   input  logic               miso,
   input  logic [LEN_W-1:0]   len,
   output logic               tx_bit,
   output logic [MAX_LEN-1:0] rx_word
);
   logic [MAX_LEN-1:0] tx_sh_q;
   logic [MAX_LEN-1:0] rx_sh_q;
   logic [MAX_LEN-1:0] rx_next;
   logic [MAX_LEN-1:0] sel_mask;

   assign rx_next  = {rx_sh_q[MAX_LEN-2:0], miso};
   assign sel_mask = {{(MAX_LEN-1){1'b0}}, 1'b1} << (len - 1'b1);
   assign tx_bit   = |(tx_sh_q & sel_mask);

   // right alignment: bits at or above the frame length read as zero
   for (genvar i = 0; i < MAX_LEN; i++) begin : g_rx_mask
      assign rx_word[i] = rx_next[i] & (LEN_W'(i) < len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh_q <= '0;
         rx_sh_q <= '0;
      end else if (clr) begin
         tx_sh_q <= '0;
         rx_sh_q <= '0;
      end else begin
         if (load)       tx_sh_q <= load_val;
         else if (shift) tx_sh_q <= tx_sh_q << 1;
         if (sample)     rx_sh_q <= rx_next;
      end
   end
endmodule

// File: rtl/csu_duplex.sv
module csu_duplex #(
   parameter  int MIN_LEN = 8,
   parameter  int MAX_LEN = 16,
   parameter  int DIV_W   = 8,
   localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               tx_en,
   input  logic               rx_en,
   input  logic [LEN_W-1:0]   frame_len,
   input  logic [DIV_W-1:0]   div_half,
   input  logic               tx_wr,
   input  logic [MAX_LEN-1:0] tx_wdata,
   input  logic               rx_rd,
   input  logic               ovr_clr,
   output logic [MAX_LEN-1:0] rx_rdata,
   output logic               tx_empty,
   output logic               tx_end,
   output logic               rx_full,
   output logic               overrun,
   output logic               sck,
   output logic               mosi,
   input  logic               miso
);
   import csu_pkg::*;

   if (MIN_LEN < 1 || MAX_LEN < MIN_LEN || MAX_LEN > 32) begin : g_bad_len
      $error("csu_duplex: frame length range is not legal");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("csu_duplex: divider width must be at least 1");
   end

   csu_state_e         state_q;
   logic               sck_q, cur_tx_q, nxt_tx_q;
   logic [LEN_W-1:0]   bitcnt_q, len_q, len_c;
   logic [DIV_W-1:0]   half_c;
   logic [MAX_LEN-1:0] tdr_q, rdr_q, rx_word;
   logic               run, tick, rise, fall, last, tx_bit;
   logic               go_tx, go_rx, start, end_f, reload;
   logic               rxf_eff, ovr_any, cont_tx, cont_rx;

   assign len_c  = (frame_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) :
                   (frame_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : frame_len;
   assign half_c = (div_half == '0) ? DIV_W'(1) : div_half;

   assign run     = (state_q == CSU_RUN);
   assign rise    = tick & ~sck_q & ~soft_rst;
   assign fall    = tick &  sck_q & ~soft_rst;
   assign last    = (bitcnt_q == len_q - 1'b1);
   assign go_tx   = tx_en & ~tx_empty & ~overrun;
   assign go_rx   = rx_en & ~tx_en & ~overrun;
   assign start   = ~run & (go_tx | go_rx) & ~soft_rst;
   assign end_f   = rise & last;
   assign reload  = fall & last;
   assign rxf_eff = rx_full & ~rx_rd;
   assign ovr_any = overrun | (rx_en & rxf_eff);
   assign cont_tx = tx_en & ~tx_empty & ~ovr_any;
   assign cont_rx = rx_en & ~tx_en & ~ovr_any;

   csu_sckgen #(.DIV_W(DIV_W)) u_sckgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .half  (half_c),
      .tick  (tick)
   );

   csu_shift #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .load     (start | reload),
      .load_val (((start & go_tx) | (reload & nxt_tx_q)) ? tdr_q : '0),
      .shift    (fall & ~last),
      .sample   (rise),
      .miso     (miso),
      .len      (len_q),
      .tx_bit   (tx_bit),
      .rx_word  (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CSU_IDLE;
         sck_q    <= 1'b1;
         bitcnt_q <= '0;
         len_q    <= LEN_W'(MIN_LEN);
         cur_tx_q <= 1'b0;
         nxt_tx_q <= 1'b0;
         tdr_q    <= '0;
         rdr_q    <= '0;
         tx_empty <= 1'b1;
         tx_end   <= 1'b1;
         rx_full  <= 1'b0;
         overrun  <= 1'b0;
      end else if (soft_rst) begin
         state_q  <= CSU_IDLE;
         sck_q    <= 1'b1;
         bitcnt_q <= '0;
         cur_tx_q <= 1'b0;
         nxt_tx_q <= 1'b0;
         tx_empty <= 1'b1;
         tx_end   <= 1'b1;
         rx_full  <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         if (rx_rd)   rx_full <= 1'b0;
         if (ovr_clr) overrun <= 1'b0;
         if (start) begin
            state_q  <= CSU_RUN;
            sck_q    <= 1'b0;
            bitcnt_q <= '0;
            len_q    <= len_c;
            cur_tx_q <= go_tx;
            if (go_tx) begin
               tx_empty <= 1'b1;
               tx_end   <= 1'b0;
            end
         end
         if (rise) begin
            sck_q <= 1'b1;
            if (end_f) begin
               if (rx_en) begin
                  if (rxf_eff) overrun <= 1'b1;
                  else begin
                     rdr_q   <= rx_word;
                     rx_full <= 1'b1;
                  end
               end
               if (tx_en & tx_empty) tx_end <= 1'b1;
               if (cont_tx | cont_rx) nxt_tx_q <= cont_tx;
               else                   state_q  <= CSU_IDLE;
            end
         end
         if (fall) begin
            sck_q <= 1'b0;
            if (last) begin
               bitcnt_q <= '0;
               len_q    <= len_c;
               cur_tx_q <= nxt_tx_q;
               if (nxt_tx_q) begin
                  tx_empty <= 1'b1;
                  tx_end   <= 1'b0;
               end
            end else begin
               bitcnt_q <= bitcnt_q + 1'b1;
            end
         end
         if (tx_wr) begin
            tdr_q    <= tx_wdata;
            tx_empty <= 1'b0;
            tx_end   <= 1'b0;
         end
      end
   end

   assign sck      = sck_q;
   assign mosi     = cur_tx_q ? tx_bit : 1'b1;
   assign rx_rdata = rdr_q;
endmodule

// File: rtl/csu_duplex_chk.sv
module csu_duplex_chk #(
   parameter int MAX_LEN = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               soft_rst,
   input logic               rx_rd,
   input logic               sck,
   input logic               mosi,
   input logic               overrun,
   input logic               rx_full,
   input logic               tx_empty,
   input logic [MAX_LEN-1:0] rx_rdata
);
   AST_MOSI_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sck) && !$past(soft_rst)) |-> $stable(mosi)); // R4

   AST_OVR_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> sck); // R8

   AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $stable(rx_rdata)); // R8

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && sck && !soft_rst) |=> !rx_full); // R7

   AST_SOFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (sck && tx_empty && !overrun && !rx_full)); // R12
endmodule

bind csu_duplex csu_duplex_chk #(.MAX_LEN(MAX_LEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .soft_rst (soft_rst),
   .rx_rd    (rx_rd),
   .sck      (sck),
   .mosi     (mosi),
   .overrun  (overrun),
   .rx_full  (rx_full),
   .tx_empty (tx_empty),
   .rx_rdata (rx_rdata)
);

// File: tb/csu_duplex_tb_top.sv
`timescale 1ns/1ps
module csu_duplex_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
   logic [4:0]  frame_len = 5'd8;
   logic [7:0]  div_half = 8'd2;
   logic        tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
   logic [15:0] tx_wdata = '0;
   logic [15:0] rx_rdata;
   logic        tx_empty, tx_end, rx_full, overrun, sck, mosi;
   logic        miso = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   int checks = 0, errors = 0;
   int rises = 0, cyc = 0, last_rise = 0, rise_gap = 0;
   logic sck_prev = 1'b1;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   csu_duplex dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en(tx_en), .rx_en(rx_en),
      .frame_len(frame_len), .div_half(div_half), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .rx_rd(rx_rd), .ovr_clr(ovr_clr), .rx_rdata(rx_rdata), .tx_empty(tx_empty),
      .tx_end(tx_end), .rx_full(rx_full), .overrun(overrun), .sck(sck), .mosi(mosi),
      .miso(miso)
   );

   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      miso <= lfsr[0];
   end

   // behavioural reference model
   int m_run, m_sck, m_bit, m_len, m_cur, m_nxt, m_tdr, m_txe, m_tend;
   int m_rxf, m_ovr, m_rdr, m_ph, m_txw, m_rxw;
   int o_ovr, o_txe, busy, ov_any, hh, ln;

   function automatic int clampl(int v);
      if (v < 8) return 8;
      if (v > 16) return 16;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_sck = 1; m_bit = 0; m_len = 8; m_cur = 0; m_nxt = 0;
         m_tdr = 0; m_txe = 1; m_tend = 1; m_rxf = 0; m_ovr = 0; m_rdr = 0;
         m_ph = 0; m_txw = 0; m_rxw = 0;
      end else if (soft_rst) begin
         m_run = 0; m_sck = 1; m_bit = 0; m_cur = 0; m_nxt = 0; m_txe = 1;
         m_tend = 1; m_rxf = 0; m_ovr = 0; m_ph = 0; m_txw = 0; m_rxw = 0;
      end else begin
         hh = (div_half == 0) ? 1 : int'(div_half);
         ln = clampl(int'(frame_len));
         o_ovr = m_ovr; o_txe = m_txe;
         busy = (m_rxf != 0 && !rx_rd) ? 1 : 0;
         if (rx_rd) m_rxf = 0;
         if (ovr_clr) m_ovr = 0;
         if (m_run == 0) begin
            if ((tx_en && o_txe == 0 && o_ovr == 0) || (rx_en && !tx_en && o_ovr == 0)) begin
               m_run = 1; m_sck = 0; m_ph = 0; m_bit = 0; m_len = ln;
               if (tx_en && o_txe == 0) begin
                  m_cur = 1; m_txw = m_tdr; m_txe = 1; m_tend = 0;
               end else begin
                  m_cur = 0; m_txw = 0;
               end
            end
         end else if (m_ph == hh - 1) begin
            m_ph = 0;
            if (m_sck == 0) begin
               m_sck = 1;
               m_rxw = ((m_rxw << 1) | int'(miso)) & 16'hFFFF;
               if (m_bit == m_len - 1) begin
                  if (rx_en) begin
                     if (busy != 0) m_ovr = 1;
                     else begin m_rdr = m_rxw & ((1 << m_len) - 1); m_rxf = 1; end
                  end
                  ov_any = (o_ovr != 0 || (rx_en && busy != 0)) ? 1 : 0;
                  if (tx_en && o_txe != 0) m_tend = 1;
                  if (tx_en && o_txe == 0 && ov_any == 0) m_nxt = 1;
                  else if (rx_en && !tx_en && ov_any == 0) m_nxt = 0;
                  else m_run = 0;
               end
            end else begin
               m_sck = 0;
               if (m_bit == m_len - 1) begin
                  m_bit = 0; m_len = ln; m_cur = m_nxt;
                  if (m_nxt != 0) begin m_txw = m_tdr; m_txe = 1; m_tend = 0; end
                  else m_txw = 0;
               end else m_bit = m_bit + 1;
            end
         end else m_ph = m_ph + 1;
         if (tx_wr) begin m_tdr = int'(tx_wdata); m_txe = 0; m_tend = 0; end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison and edge bookkeeping
   always @(negedge clk) begin
      cyc++;
      if (sck_prev == 1'b0 && sck == 1'b1) begin
         rises++;
         rise_gap = cyc - last_rise;
         last_rise = cyc;
      end
      sck_prev = sck;
      if (rst_n && !done) begin
         chk("R4 sck", int'(sck), m_sck);
         chk("R4 mosi", int'(mosi), m_cur != 0 ? ((m_txw >> (m_len - 1 - m_bit)) & 1) : 1);
         chk("R2 tx_empty", int'(tx_empty), m_txe);
         chk("R6 tx_end", int'(tx_end), m_tend);
         chk("R7 rx_full", int'(rx_full), m_rxf);
         chk("R8 overrun", int'(overrun), m_ovr);
         chk("R7 rx_rdata", int'(rx_rdata), m_rdr);
      end
   end

   task automatic tk(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wr(input int v);
      @(negedge clk); tx_wr = 1'b1; tx_wdata = 16'(v);
      @(negedge clk); tx_wr = 1'b0;
   endtask
   task automatic rd();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask
   task automatic oclr();
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
   endtask
   task automatic wait_idle();
      tk(2);
      while (m_run != 0) @(negedge clk);
      tk(4);
   endtask
   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #600000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog act=hung exp=done");
         finish_run();
      end
   end

   initial begin
      int snap;
      tk(3);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      chk("R1 sck", int'(sck), 1);
      chk("R1 tx_empty", int'(tx_empty), 1);
      chk("R1 tx_end", int'(tx_end), 1);
      chk("R1 rx_full", int'(rx_full), 0);
      chk("R1 overrun", int'(overrun), 0);
      chk("R1 rx_rdata", int'(rx_rdata), 0);

      // R2 R3 single full-duplex frame
      tx_en = 1'b1; rx_en = 1'b1; rises = 0;
      wr(16'hA5);
      wait_idle();
      chk("R3 rises len8", rises, 8);
      chk("R6 tx_end at stop", int'(tx_end), 1);
      chk("R7 rx_full set", int'(rx_full), 1);
      chk("R2 tx_empty after copy", int'(tx_empty), 1);
      chk("R4 half period gap", rise_gap, 4);
      rd();

      // R5 back-to-back frames
      rises = 0;
      wr(16'h3C); tk(3); wr(16'hC3);
      while (!rx_full) @(negedge clk);
      rd();
      wait_idle();
      chk("R5 continuous rises", rises, 16);
      chk("R5 no overrun", int'(overrun), 0);
      rd();

      // R8 overrun halts, then resumes after clear
      rises = 0;
      wr(16'h01); tk(3); wr(16'h02);
      while (!rx_full) @(negedge clk);
      snap = int'(rx_rdata);
      wr(16'h03);
      wait_idle();
      chk("R8 overrun set", int'(overrun), 1);
      chk("R8 halted rises", rises, 16);
      chk("R8 data pending", int'(tx_empty), 0);
      chk("R8 rdata kept", int'(rx_rdata), snap);
      rises = 0;
      rd(); oclr();
      wait_idle();
      chk("R8 resumed rises", rises, 8);
      chk("R8 cleared", int'(overrun), 0);
      rd();

      // R3 R7 other lengths and clamping
      frame_len = 5'd12; rises = 0;
      wr(16'hABC); wait_idle();
      chk("R3 rises len12", rises, 12);
      chk("R7 upper bits zero", int'(rx_rdata >> 12), 0);
      rd();
      frame_len = 5'd20; rises = 0;
      wr(16'hF00D); wait_idle();
      chk("R3 rises clamp high", rises, 16);
      rd();
      frame_len = 5'd5; rises = 0;
      wr(16'h5A); wait_idle();
      chk("R3 rises clamp low", rises, 8);
      rd();

      // R9 transmit only
      rx_en = 1'b0; snap = int'(rx_rdata); rises = 0;
      wr(16'h55); wait_idle();
      chk("R9 rx_full untouched", int'(rx_full), 0);
      chk("R9 rdata untouched", int'(rx_rdata), snap);
      chk("R9 rises", rises, 8);

      // R11 receive-enable cleared first
      rx_en = 1'b1;
      wr(16'h11); wait_idle(); rd();
      rises = 0;
      @(negedge clk); rx_en = 1'b0;
      tk(2); tx_en = 1'b0;
      tk(60);
      chk("R11 rx first no clock", rises, 0);

      // R11 both cleared together
      tx_en = 1'b1; rx_en = 1'b1;
      wr(16'h22); wait_idle(); rd();
      rises = 0;
      @(negedge clk); tx_en = 1'b0; rx_en = 1'b0;
      tk(60);
      chk("R11 both no clock", rises, 0);

      // R10 R11 transmit-enable cleared alone
      tx_en = 1'b1; rx_en = 1'b1;
      wr(16'h33); wait_idle(); rd();
      rises = 0;
      @(negedge clk); tx_en = 1'b0;
      tk(10);
      chk("R11 tx alone clocks", int'(rises > 0), 1);
      wait_idle();
      chk("R10 rx-only frames", rises, 16);
      chk("R10 stopped by overrun", int'(overrun), 1);
      @(negedge clk); rx_en = 1'b0;
      rd(); oclr(); tk(4);

      // R4 divider variants
      tx_en = 1'b1; rx_en = 1'b1; div_half = 8'd3;
      wr(16'h96); wait_idle();
      chk("R4 gap div3", rise_gap, 6);
      rd();
      div_half = 8'd0;
      wr(16'h69); wait_idle();
      chk("R4 gap div0", rise_gap, 2);
      rd();
      div_half = 8'd2;

      // R12 soft reset mid-frame
      snap = int'(rx_rdata);
      wr(16'h99); tk(10);
      @(negedge clk); soft_rst = 1'b1;
      tk(2); soft_rst = 1'b0;
      tk(1);
      chk("R12 sck idle", int'(sck), 1);
      chk("R12 tx_empty", int'(tx_empty), 1);
      chk("R12 rx_full", int'(rx_full), 0);
      chk("R12 rdata kept", int'(rx_rdata), snap);
      rises = 0; tk(40);
      chk("R12 no restart", rises, 0);
      wr(16'h66); wait_idle();
      chk("R12 works after", rises, 8);

      finish_run();
   end
endmodule